// File: doc/BRIEF.md
# Front-Panel Examine Jam Sequencer

This block sits between a front panel and an 8-bit processor with a 16-bit address bus. It keeps the processor parked in a wait state at the start of every machine cycle. A machine cycle only proceeds when the panel grants it.

A single-step press grants exactly one machine cycle. A whole instruction of three bytes therefore needs three presses. An examine press grants the next three memory-read cycles and replaces the data the processor reads in them. The forced bytes are, in order, an absolute-jump opcode, the low byte of the switch address and the high byte of the switch address.

The forced bytes are counted by read cycle. They are not aligned to opcode fetches. If the processor is part-way through an instruction when examine is pressed, it lands somewhere other than the switch address, in a way that is repeatable. Once the third forced read has completed, the block parks the processor again. The latched address and status lights then show where it stopped.

Top module: `fp_jam_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, `ready` and `jam_en` are low, `jam_data` is zero and both light registers are zero. No forced sequence is pending after reset.
- R2: Without a button press, no machine cycle is released. A cycle whose start strobe has been seen stays held with `ready` low for any length of time.
- R3: One rising edge of `step_btn` releases exactly one machine cycle with no forced data. Holding the button high produces no further releases. A press made before the cycle start is kept until that cycle arrives.
- R4: On every `cyc_start`, `status_lights` takes the 8-bit status word and `addr_lights` takes the address. Bit 5 of the status word marks an opcode fetch and bit 7 marks a memory read. A memory write shows as 0x00, an operand read as 0x80 and an opcode fetch as 0xA0.
- R5: A rising edge of `exam_btn` forces the next three memory-read cycles. They are released with `jam_en` high and `jam_data` equal to 0xC3, then the switch low byte, then the switch high byte.
- R6: The forced sequence ignores the opcode-fetch bit. Take a jump 0xC3 0x00 0x00 at address 0, stepped once and then examined with switches 0x0000: the processor stops with an opcode fetch pending at 0x00C4. A second examine then stops it at a fetch from 0x0000.
- R7: After the third forced read is released, the next machine cycle is held until a new press.
- R8: The switch address is captured on the examine press. Switch changes during the sequence do not alter the forced bytes.
- R9: Step and examine presses that arrive while a forced sequence is in progress are discarded. They cause no extra release afterwards.
- R10: A machine cycle whose status word has bit 7 clear is released during a forced sequence with `jam_en` low. It does not count toward the three forced bytes.
- R11: Each release is a `ready` pulse exactly one clock long. `jam_en` is high only in the clock of a released memory read of a forced sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe at the start of each machine cycle |
| cpu_status | input | 8 | Status word, valid with `cyc_start` |
| cpu_addr | input | 16 | Address bus, valid with `cyc_start` |
| sw_addr | input | 16 | Panel address switches |
| step_btn | input | 1 | Debounced single-step button |
| exam_btn | input | 1 | Debounced examine button |
| jam_data | output | 8 | Byte forced onto the processor data input |
| jam_en | output | 1 | Selects `jam_data` instead of memory data |
| ready | output | 1 | One-clock pulse that releases the held cycle |
| status_lights | output | 8 | Status word latched at the last cycle start |
| addr_lights | output | 16 | Address latched at the last cycle start |

## Verification
The assertions make three assumptions about the processor. It raises `cyc_start` once per machine cycle. It never raises it while a cycle is still held or in the clock of a `ready` pulse. Its status and address are valid in the strobe clock, and the buttons arrive already debounced. The bench respects these assumptions with a small processor model that executes NOP, jump and store. The model raises the next strobe only on the falling edge after `ready` has dropped. Button presses are held for whole clocks and driven on falling edges.

// File: rtl/fp_jam_pkg.sv
package fp_jam_pkg;
  // Forced-byte phase; counts down, the value gives the byte still to go.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2,
    PH_OP   = 2'd3
  } jam_ph_t;

  localparam logic [7:0] JMP_OPCODE = 8'hC3;
endpackage

// File: rtl/fp_press_edge.sv
module fp_press_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] btn,
  output logic [N-1:0] press
);
  for (genvar g = 0; g < N; g++) begin : g_edge
    logic btn_q;
    logic press_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        btn_q   <= 1'b0;
        press_q <= 1'b0;
      end else begin
        btn_q   <= btn[g];
        press_q <= btn[g] & ~btn_q;
      end
    end
    assign press[g] = press_q;
  end
endmodule

// File: rtl/fp_jam_seq.sv
module fp_jam_seq
  import fp_jam_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] JMP_OP = JMP_OPCODE,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] sw_addr,
  input  logic          consume,
  output logic          active,
  output logic [DW-1:0] jam_byte
);
  jam_ph_t       ph;
  logic [AW-1:0] tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      tgt <= '0;
    end else if (load && ph == PH_IDLE) begin
      ph  <= PH_OP;
      tgt <= sw_addr;
    end else if (consume && ph != PH_IDLE) begin
      ph <= jam_ph_t'(ph - 2'd1);
    end
  end

  assign active = (ph != PH_IDLE);

  always_comb begin
    case (ph)
      PH_OP:   jam_byte = JMP_OP;
      PH_LO:   jam_byte = tgt[DW-1:0];
      PH_HI:   jam_byte = tgt[AW-1:DW];
      default: jam_byte = '0;
    endcase
  end

  // R8
  tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(tgt));

  // R5
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LO) |-> ($past(ph) == PH_OP || $past(ph) == PH_LO));
endmodule

// File: rtl/fp_cycle_gate.sv
module fp_cycle_gate #(
  parameter int DW = 8,
  parameter int SW = 8,
  parameter int RD_BIT = 7,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_start,
  input  logic [SW-1:0] status,
  input  logic [AW-1:0] addr,
  input  logic          step_press,
  input  logic          jam_active,
  input  logic [DW-1:0] jam_byte,
  output logic          ready,
  output logic          jam_en,
  output logic [DW-1:0] jam_data,
  output logic [SW-1:0] st_lights,
  output logic [AW-1:0] addr_lights,
  output logic          consume
);
  logic pend;
  logic credit;
  logic grant;

  assign grant   = pend && (credit || jam_active);
  assign consume = grant && jam_active && st_lights[RD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ready       <= 1'b0;
      jam_en      <= 1'b0;
      jam_data    <= '0;
      st_lights   <= '0;
      addr_lights <= '0;
      pend        <= 1'b0;
      credit      <= 1'b0;
    end else begin
      ready    <= grant;
      jam_en   <= consume;
      jam_data <= consume ? jam_byte : '0;
      if (cyc_start) begin
        st_lights   <= status;
        addr_lights <= addr;
        pend        <= 1'b1;
      end else if (grant) begin
        pend <= 1'b0;
      end
      if (jam_active)      credit <= 1'b0;
      else if (step_press) credit <= 1'b1;
      else if (grant)      credit <= 1'b0;
    end
  end

  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R11
  jam_en_read_chk: assert property (@(posedge clk) disable iff (rst)
    jam_en |-> (ready && st_lights[RD_BIT]));
endmodule

// File: rtl/fp_jam_ctrl.sv
module fp_jam_ctrl
  import fp_jam_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 8,
  parameter int RD_BIT = 7,
  parameter logic [DW-1:0] JMP_OP = JMP_OPCODE,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_start,
  input  logic [SW-1:0] cpu_status,
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] sw_addr,
  input  logic          step_btn,
  input  logic          exam_btn,
  output logic [DW-1:0] jam_data,
  output logic          jam_en,
  output logic          ready,
  output logic [SW-1:0] status_lights,
  output logic [AW-1:0] addr_lights
);
  logic [1:0]    press;
  logic          step_ok;
  logic          jam_active;
  logic          consume;
  logic [DW-1:0] jam_byte;

  fp_press_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .btn   ({exam_btn, step_btn}),
    .press (press)
  );

  // Examine wins over a simultaneous step.
  assign step_ok = press[0] & ~press[1];

  fp_jam_seq #(.DW(DW), .JMP_OP(JMP_OP)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (press[1]),
    .sw_addr  (sw_addr),
    .consume  (consume),
    .active   (jam_active),
    .jam_byte (jam_byte)
  );

  fp_cycle_gate #(.DW(DW), .SW(SW), .RD_BIT(RD_BIT)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .cyc_start   (cyc_start),
    .status      (cpu_status),
    .addr        (cpu_addr),
    .step_press  (step_ok),
    .jam_active  (jam_active),
    .jam_byte    (jam_byte),
    .ready       (ready),
    .jam_en      (jam_en),
    .jam_data    (jam_data),
    .st_lights   (status_lights),
    .addr_lights (addr_lights),
    .consume     (consume)
  );
endmodule

// File: tb/test_fp_jam_ctrl.sv
module test_fp_jam_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;
  localparam logic [7:0] ST_FETCH = 8'hA0;
  localparam logic [7:0] ST_READ  = 8'h80;
  localparam logic [7:0] ST_WRITE = 8'h00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_start = 1'b0;
  logic [7:0]  cpu_status = '0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] sw_addr = '0;
  logic        step_btn = 1'b0;
  logic        exam_btn = 1'b0;
  logic [7:0]  jam_data;
  logic        jam_en;
  logic        ready;
  logic [7:0]  status_lights;
  logic [15:0] addr_lights;

  int n_chk  = 0;
  int n_fail = 0;
  int n_clk  = 0;

  typedef struct {
    logic [15:0] a;
    logic [7:0]  st;
    logic        en;
    logic [7:0]  d;
    string       req;
  } rel_t;
  rel_t exp_q[$];

  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_jam_ctrl i_fp_jam_ctrl (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cpu_status(cpu_status),
    .cpu_addr(cpu_addr), .sw_addr(sw_addr), .step_btn(step_btn),
    .exam_btn(exam_btn), .jam_data(jam_data), .jam_en(jam_en),
    .ready(ready), .status_lights(status_lights), .addr_lights(addr_lights)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    n_clk++;
    if (n_clk == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d clocks, expected fewer", n_clk);
      finish_run();
    end
  end

  // Processor model: NOP (anything else), JMP 0xC3, STA 0x32.
  initial begin
    logic [15:0] pc, wr_a, a;
    logic [1:0]  ph;
    logic [7:0]  op, lo, d, st;
    pc = '0; ph = 2'd0; op = '0; lo = '0; wr_a = '0;
    wait (rst == 1'b0);
    forever begin
      @(negedge clk);
      case (ph)
        2'd0:    begin st = ST_FETCH; a = pc;   end
        2'd3:    begin st = ST_WRITE; a = wr_a; end
        default: begin st = ST_READ;  a = pc;   end
      endcase
      cpu_status = st; cpu_addr = a; cyc_start = 1'b1;
      @(negedge clk);
      cyc_start = 1'b0;
      while (!ready) @(negedge clk);
      d = jam_en ? jam_data : mem[a[7:0]];
      case (ph)
        2'd0: begin op = d; pc = pc + 16'd1;
                ph = (d == 8'hC3 || d == 8'h32) ? 2'd1 : 2'd0; end
        2'd1: begin lo = d; pc = pc + 16'd1; ph = 2'd2; end
        2'd2: begin
                pc = pc + 16'd1;
                if (op == 8'hC3) begin pc = {d, lo}; ph = 2'd0; end
                else begin wr_a = {d, lo}; ph = 2'd3; end
              end
        default: begin mem[wr_a[7:0]] = 8'h00; ph = 2'd0; end
      endcase
    end
  end

  // Scoreboard monitor: every release is compared with the next expected item.
  always @(negedge clk) begin
    if (!rst && ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R9: unexpected release, actual addr=%h st=%h en=%b, expected none",
                 addr_lights, status_lights, jam_en);
      end else begin
        rel_t e;
        e = exp_q.pop_front();
        if (addr_lights !== e.a || status_lights !== e.st || jam_en !== e.en ||
            (e.en && jam_data !== e.d)) begin
          n_fail++;
          $display("FAIL %s: release actual addr=%h st=%h en=%b data=%h, expected addr=%h st=%h en=%b data=%h",
                   e.req, addr_lights, status_lights, jam_en, jam_data, e.a, e.st, e.en, e.d);
        end
      end
    end
  end

  task automatic expect_rel(input logic [15:0] a, input logic [7:0] st,
                            input logic en, input logic [7:0] d, input string req);
    rel_t e;
    e.a = a; e.st = st; e.en = en; e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic press_step(input int hold);
    step_btn = 1'b1;
    repeat (hold) @(negedge clk);
    step_btn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic press_exam(input logic [15:0] sw, input int hold);
    sw_addr = sw;
    @(negedge clk);
    exam_btn = 1'b1;
    repeat (hold) @(negedge clk);
    exam_btn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 500) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s: releases missing, actual %0d left, expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic check_lights(input logic [15:0] a, input logic [7:0] st, input string req);
    n_chk++;
    if (addr_lights !== a || status_lights !== st) begin
      n_fail++;
      $display("FAIL %s: lights actual addr=%h st=%h, expected addr=%h st=%h",
               req, addr_lights, status_lights, a, st);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h00] = 8'hC3; mem[8'h01] = 8'h00; mem[8'h02] = 8'h00;
    mem[8'h40] = 8'h32; mem[8'h41] = 8'h10; mem[8'h42] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (ready !== 1'b0 || jam_en !== 1'b0 || jam_data !== 8'h00 ||
        status_lights !== 8'h00 || addr_lights !== 16'h0000) begin
      n_fail++;
      $display("FAIL R1: reset actual ready=%b en=%b data=%h st=%h addr=%h, expected all zero",
               ready, jam_en, jam_data, status_lights, addr_lights);
    end
    rst = 1'b0;

    // R2: held with no press; R4 fetch lights
    repeat (40) @(negedge clk);
    check_lights(16'h0000, ST_FETCH, "R2");

    // R3: long hold gives one release; R4 operand read shows M1 off
    expect_rel(16'h0000, ST_FETCH, 1'b0, 8'h00, "R3");
    press_step(30);
    drain("R3");
    check_lights(16'h0001, ST_READ, "R4");

    // R6: misaligned examine lands at 0x00C4, R7 stops there
    expect_rel(16'h0001, ST_READ,  1'b1, 8'hC3, "R6");
    expect_rel(16'h0002, ST_READ,  1'b1, 8'h00, "R6");
    expect_rel(16'h00C3, ST_FETCH, 1'b1, 8'h00, "R6");
    press_exam(16'h0000, 2);
    drain("R6");
    check_lights(16'h00C4, ST_FETCH, "R7");

    // R6: second examine is aligned
    expect_rel(16'h00C4, ST_FETCH, 1'b1, 8'hC3, "R6");
    expect_rel(16'h00C5, ST_READ,  1'b1, 8'h00, "R6");
    expect_rel(16'h00C6, ST_READ,  1'b1, 8'h00, "R6");
    press_exam(16'h0000, 2);
    drain("R6");
    check_lights(16'h0000, ST_FETCH, "R6");

    // R5 + R8: aligned examine, switches changed mid-sequence
    expect_rel(16'h0000, ST_FETCH, 1'b1, 8'hC3, "R5");
    expect_rel(16'h0001, ST_READ,  1'b1, 8'h40, "R8");
    expect_rel(16'h0002, ST_READ,  1'b1, 8'h00, "R8");
    press_exam(16'h0040, 2);
    sw_addr = 16'hFFFF;
    drain("R8");
    sw_addr = 16'h0000;
    check_lights(16'h0040, ST_FETCH, "R5");

    // R3: three steps through a store, stopping on its write cycle
    expect_rel(16'h0040, ST_FETCH, 1'b0, 8'h00, "R3");
    press_step(2);
    drain("R3");
    expect_rel(16'h0041, ST_READ, 1'b0, 8'h00, "R3");
    press_step(2);
    drain("R3");
    expect_rel(16'h0042, ST_READ, 1'b0, 8'h00, "R3");
    press_step(2);
    drain("R3");
    check_lights(16'h0010, ST_WRITE, "R4");

    // R10: write released unforced; R9: step during sequence discarded
    expect_rel(16'h0010, ST_WRITE, 1'b0, 8'h00, "R10");
    expect_rel(16'h0043, ST_FETCH, 1'b1, 8'hC3, "R10");
    expect_rel(16'h0044, ST_READ,  1'b1, 8'h80, "R10");
    expect_rel(16'h0045, ST_READ,  1'b1, 8'h00, "R10");
    press_exam(16'h0080, 2);
    press_step(2);
    drain("R9");
    check_lights(16'h0080, ST_FETCH, "R9");

    // R3: a later step still releases exactly one cycle
    expect_rel(16'h0080, ST_FETCH, 1'b0, 8'h00, "R3");
    press_step(2);
    drain("R3");
    check_lights(16'h0081, ST_FETCH, "R3");

    finish_run();
  end
endmodule